// File: doc/BRIEF.md
# Binary Fractional Rate Multiplier

This block divides an input clock by a programmable fraction with a power-of-two denominator. A free-running binary counter of `WIDTH` bits advances on every clock on which the enable is high. Its state is decoded into `WIDTH` pulse trains with binary weights that never overlap. The heaviest train fires on half of all enabled clocks, the next on a quarter, and so on. A rate word chooses which trains are merged onto one output strobe. Over every aligned window of 2^WIDTH enabled clocks, that strobe is high on exactly as many clocks as the rate word's value.

The spacing between strobes is not uniform. Only the count per window is exact. Each strobe is one clock wide and stays aligned to the input clock. The decode uses only the registered counter state and the enable, so ripple transients never reach the outputs. A new rate word affects the output on the same cycle it is applied and does not disturb the counter, so software can retune the rate on the fly.

Top module: `rate_mult`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the counter to zero. On the first enabled cycle after reset, `trains` equals 1, because only P1 is active in state zero.
- R2: At most one bit of `trains` is high in any cycle.
- R3: The counter advances by one, wrapping, on each clock edge where `en` is high. Bit k-1 of `trains` (train Pk) is high when `en` is high, counter bits 0 to k-2 are all one and counter bit k-1 is zero. Train Pk is therefore high on 2^(WIDTH-k) of every 2^WIDTH enabled clocks.
- R4: `pulse_out` is high when some bit `trains[k-1]` is high together with `rate[WIDTH-k]`, so P1 is paired with the rate MSB. Over each aligned window of 2^WIDTH enabled clocks starting from counter zero, `pulse_out` is high on exactly `rate` clocks, and this holds window after window.
- R5: A rate of zero never raises `pulse_out`. An all-ones rate gives 2^WIDTH-1 strobes per window, because the all-ones counter state decodes to no train.
- R6: While `en` is low, the counter holds its value and all of `trains` and `pulse_out` stay low. The count resumes from the held value once `en` returns.
- R7: A change of `rate` alters `pulse_out` in the same cycle and leaves the counter untouched.
- R8: No train is high on two consecutive enabled clocks, so each pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; advances the counter and gates every output |
| rate | input | WIDTH | Rate word; strobes per window of 2^WIDTH enabled clocks |
| trains | output | WIDTH | Binary-weighted pulse trains; bit 0 is the heaviest (P1) |
| pulse_out | output | 1 | Merged output strobe |

## Verification
A counter that skips, repeats or fails to hold while disabled moves every train. The effect shows at the ports on the very next enabled clock as the wrong `trains` bit, or as a second bit high at once. A wrong pairing between rate bits and trains, or a wrong decode term, may show only as a miscount. Such a miscount is visible once a full window of 2^WIDTH enabled clocks has been counted, which is 16 clocks at the default width. Rate changes in mid-window expose a counter that restarts, because the train seen at that instant differs from the one a zero state would give.

// File: rtl/rmul_pkg.sv
`timescale 1ns/1ps
package rmul_pkg;
   // Widest counter the block supports; keeps the decode AND chain short.
   localparam int RM_MAX_WIDTH = 16;

   // Number of pulses train idx (0-based) gives per 2^width enabled clocks.
   function automatic int rm_train_weight(input int width, input int idx);
      return 1 << (width - 1 - idx);
   endfunction
endpackage

// File: rtl/rmul_counter.sv
`timescale 1ns/1ps
module rmul_counter #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (en)
         count <= count + STEP;
   end
endmodule

// File: rtl/rmul_decoder.sv
`timescale 1ns/1ps
module rmul_decoder #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] count,
   input  logic             en,
   output logic [WIDTH-1:0] trains
);
   // Train k fires when all bits below k are one and bit k is zero:
   // the state in which bit k is about to toggle from 0 to 1.
   for (genvar k = 0; k < WIDTH; k++) begin : g_train
      if (k == 0) begin : g_lsb
         assign trains[k] = en & ~count[0];
      end else begin : g_upper
         assign trains[k] = en & (&count[k-1:0]) & ~count[k];
      end
   end
endmodule

// File: rtl/rmul_combine.sv
`timescale 1ns/1ps
module rmul_combine #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] trains,
   input  logic [WIDTH-1:0] rate,
   output logic             pulse
);
   logic [WIDTH-1:0] picked;

   // Heaviest train (index 0) is paired with the rate MSB.
   for (genvar k = 0; k < WIDTH; k++) begin : g_pick
      assign picked[k] = trains[k] & rate[WIDTH-1-k];
   end

   assign pulse = |picked;
endmodule

// File: rtl/rate_mult.sv
`timescale 1ns/1ps
module rate_mult #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] rate,
   output logic [WIDTH-1:0] trains,
   output logic             pulse_out
);
   import rmul_pkg::*;

   if (WIDTH < 1 || WIDTH > RM_MAX_WIDTH) begin : g_bad_width
      $error("rate_mult: WIDTH must lie between 1 and %0d", RM_MAX_WIDTH);
   end

   logic [WIDTH-1:0] count_q;
   logic [WIDTH-1:0] train_vec;
   logic             merged;

   rmul_counter #(.WIDTH(WIDTH)) u_count (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .count (count_q)
   );

   rmul_decoder #(.WIDTH(WIDTH)) u_decode (
      .count  (count_q),
      .en     (en),
      .trains (train_vec)
   );

   rmul_combine #(.WIDTH(WIDTH)) u_merge (
      .trains (train_vec),
      .rate   (rate),
      .pulse  (merged)
   );

   assign trains    = train_vec;
   assign pulse_out = merged;
endmodule

// File: rtl/rate_mult_chk.sv
`timescale 1ns/1ps
module rate_mult_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [WIDTH-1:0] rate,
   input logic [WIDTH-1:0] count,
   input logic [WIDTH-1:0] trains,
   input logic             pulse_out
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> count == '0);  // R1
   AST_TRAINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(trains));  // R2
   AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
      en |=> count == $past(count) + ONE);  // R3
   AST_ZERO_RATE_SILENT: assert property (@(posedge clk) disable iff (rst)
      rate == '0 |-> !pulse_out);  // R5
   AST_FULL_STATE_SILENT: assert property (@(posedge clk) disable iff (rst)
      count == '1 |-> trains == '0);  // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !en |-> (trains == '0 && !pulse_out));  // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(count));  // R6
   AST_SINGLE_CLOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
      (past_ok && en && $past(en)) |-> ((trains & $past(trains)) == '0));  // R8
endmodule

bind rate_mult rate_mult_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .rate      (rate),
   .count     (count_q),
   .trains    (trains),
   .pulse_out (pulse_out)
);

// File: tb/rate_mult_test.sv
`timescale 1ns/1ps
module rate_mult_test;
   localparam int W   = 4;
   localparam int WIN = 1 << W;

   // {rate, expected strobes per window}
   localparam logic [7:0] VEC [16] = '{
      8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77,
      8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] rate = '0;
   logic [W-1:0] trains;
   logic         pulse_out;

   int checks = 0;
   int errors = 0;
   int pcount;
   int excl_bad;
   int rep_bad;
   int tcount [W];

   always #4 clk = ~clk;

   rate_mult #(.WIDTH(W)) uut (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .rate      (rate),
      .trains    (trains),
      .pulse_out (pulse_out)
   );

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   // Leaves the bench at a falling edge with the counter at zero.
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // One full window of enabled clocks at a fixed rate, sampled mid-cycle.
   task automatic run_window(input logic [W-1:0] r);
      logic [W-1:0] prev;
      prev     = '0;
      pcount   = 0;
      excl_bad = 0;
      rep_bad  = 0;
      for (int k = 0; k < W; k++) tcount[k] = 0;
      for (int i = 0; i < WIN; i++) begin
         rate = r;
         en   = 1'b1;
         #1;
         pcount += int'(pulse_out);
         for (int k = 0; k < W; k++) tcount[k] += int'(trains[k]);
         if ($countones(trains) > 1) excl_bad++;
         if ((trains & prev) != '0) rep_bad++;
         prev = trains;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state and first enabled state
      en = 1'b0;
      #1;
      chk("R1 trains idle after reset", int'(trains), 0);
      chk("R1 pulse idle after reset", int'(pulse_out), 0);
      en = 1'b1;
      rate = '0;
      #1;
      chk("R1 first enabled state is P1", int'(trains), 1);
      @(negedge clk);

      // Table walk over every rate value
      for (int v = 0; v < 16; v++) begin
         do_reset();
         run_window(VEC[v][7:4]);
         chk($sformatf("R4 strobes rate=%0d", VEC[v][7:4]), pcount, int'(VEC[v][3:0]));
         for (int k = 0; k < W; k++)
            chk($sformatf("R3 train %0d weight", k + 1), tcount[k], 1 << (W - 1 - k));
         chk("R2 overlapping trains", excl_bad, 0);
         chk("R8 train repeated on consecutive clocks", rep_bad, 0);
      end

      // R4: consecutive aligned windows without reset
      do_reset();
      run_window(4'd5);
      chk("R4 first window rate 5", pcount, 5);
      run_window(4'd5);
      chk("R4 second window rate 5", pcount, 5);

      // R5: all-ones counter state decodes to nothing
      do_reset();
      en = 1'b1;
      rate = '1;
      repeat (15) @(negedge clk);
      #1;
      chk("R5 no train in all-ones state", int'(trains), 0);
      chk("R5 no strobe in all-ones state", int'(pulse_out), 0);
      @(negedge clk);
      rate = '0;
      pcount = 0;
      for (int i = 0; i < WIN; i++) begin
         #1;
         pcount += int'(pulse_out);
         @(negedge clk);
      end
      chk("R5 zero rate gives no strobes", pcount, 0);

      // R6: hold while disabled
      do_reset();
      en = 1'b1;
      rate = '1;
      repeat (3) @(negedge clk);
      en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         #1;
         chk("R6 trains low while disabled", int'(trains), 0);
         chk("R6 strobe low while disabled", int'(pulse_out), 0);
         @(negedge clk);
      end
      en = 1'b1;
      #1;
      chk("R6 resumes at held state 3 (P3)", int'(trains), 4);
      chk("R6 resumes with strobe", int'(pulse_out), 1);
      @(negedge clk);

      // R6: gapped enable, 16 enabled clocks out of 32
      do_reset();
      rate = 4'b1011;
      pcount = 0;
      for (int i = 0; i < 2 * WIN; i++) begin
         en = ((i % 2) == 0);
         #1;
         pcount += int'(pulse_out);
         @(negedge clk);
      end
      chk("R6 gapped enable strobe count", pcount, 11);

      // R7: rate change mid-window
      do_reset();
      en = 1'b1;
      rate = 4'b1000;
      pcount = 0;
      for (int i = 0; i < 9; i++) begin
         #1;
         pcount += int'(pulse_out);
         @(negedge clk);
      end
      rate = 4'b0001;
      #1;
      chk("R7 counter kept at state 9 (P2)", int'(trains), 2);
      chk("R7 new rate applied at once", int'(pulse_out), 0);
      for (int i = 9; i < WIN; i++) begin
         #1;
         pcount += int'(pulse_out);
         @(negedge clk);
      end
      chk("R7 window total after change", pcount, 5);

      en = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule